// File: doc/BRIEF.md
# Cache Transaction Stall Counters

This block is instrumentation that sits next to a level-one cache controller. Each bus transaction the cache starts belongs to one of four kinds: a line burst read after an instruction-cache miss, a line burst read after a data-cache miss, a single-word read from a non-cacheable region, or a single-word write. With the attached direct-mapped caches of 16 lines of 8 words, a miss moves an 8-word burst. For every kind the block keeps two saturating counters. One counts how many transactions of that kind started. The other counts how many cycles the processor was frozen while such a transaction was outstanding. It also counts retired instructions and elapsed cycles.

Software outside the block divides freeze cycles by events to get the average cost of each kind. Because requests wait for a shared bus, that cost is generally not an integer. It also divides cycles by instructions to get cycles per instruction. A figure is only meaningful when every counter is taken at the same instant, for example the cycle the application exits. A snapshot strobe therefore copies every live counter into a shadow bank in one cycle, and the read port only ever shows the shadow bank. A clear strobe zeroes the live counters so a new measurement can start.

Top module: `txn_stall_counters`

## Requirements
- R1: `txn_kind` encodes the transaction kind as 0 = instruction-miss burst, 1 = data-miss burst, 2 = uncached word read, 3 = word write. A transaction is outstanding while `txn_req` is high. It counts as one new event only in a cycle where `txn_req` is high and was low in the previous cycle, however long it stays high.
- R2: Each new event adds one to the event counter of the kind presented in that cycle. The event counters of the other kinds stay unchanged.
- R3: Each cycle with both `txn_req` and `cpu_freeze` high adds one to the freeze counter of the kind on `txn_kind` in that cycle.
- R4: A cycle with `cpu_freeze` high and `txn_req` low changes no freeze counter.
- R5: The instruction counter adds one in every cycle with `instr_retire` high.
- R6: The cycle counter adds one in every cycle that has neither reset nor clear.
- R7: A cycle with `snap` high copies every live counter into the shadow bank, holding the values from before that cycle's own activity. The read port shows only shadow values, so live changes are invisible until the next snapshot.
- R8: A cycle with `clr` high zeroes all live counters and discards that cycle's activity. It leaves the shadow bank unchanged. When `snap` and `clr` are high in the same cycle, the shadow bank receives the values from before the clear.
- R9: Every counter is `CNT_W` bits wide (32 by default). It stops at its all-ones value instead of wrapping.
- R10: A cycle with `rd_en` high returns the shadow entry at `rd_addr` on `rd_data`, with `rd_valid` high, in the following cycle. Addresses 0-3 are the event counters of kinds 0-3, addresses 4-7 are the freeze counters of kinds 0-3, address 8 is instructions and address 9 is cycles. Any other address reads as zero. `rd_valid` is low in cycles that follow no read.
- R11: Synchronous active-high `rst` zeroes all live and shadow counters and `rd_valid`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_req | input | 1 | High while a cache bus transaction is outstanding |
| txn_kind | input | 2 | Kind of the outstanding transaction |
| cpu_freeze | input | 1 | Processor is frozen this cycle |
| instr_retire | input | 1 | One instruction retires this cycle |
| snap | input | 1 | Copy all live counters into the shadow bank |
| clr | input | 1 | Zero all live counters |
| rd_en | input | 1 | Read strobe for the shadow bank |
| rd_addr | input | 4 | Shadow entry to read |
| rd_data | output | CNT_W | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |

## Verification
The main function is exercised with several distinct patterns:
- **Attribution per kind:** a long instruction-miss transaction with freeze on only some of its cycles, then short transactions of each other kind. This separates counting per cycle from counting per transaction, and attribution to the correct kind from attribution to a fixed one.
- **Event edge detection:** two one-cycle writes separated by an idle cycle, together with freeze raised while no request is outstanding. These tell correct edge detection apart from level counting, and gated freeze accounting apart from ungated accounting.
- **Snapshot and clear interaction:** reading without a new snapshot after more activity shows whether reads see the shadow bank or the live counters. A simultaneous snapshot and clear shows which of the two takes effect first.
- **Saturation:** a run of several hundred cycles against a narrow counter separates saturation from wrap-around. Because the request is held high the whole time, the same run also confirms that a long request is counted as a single event.

// File: rtl/txn_cnt_pkg.sv
package txn_cnt_pkg;

  typedef enum logic [1:0] {
    KIND_IFETCH   = 2'd0,
    KIND_DLOAD    = 2'd1,
    KIND_UNCACHED = 2'd2,
    KIND_STORE    = 2'd3
  } txn_kind_e;

  localparam int NUM_KINDS  = 4;
  localparam int IDX_EVT0   = 0;
  localparam int IDX_FRZ0   = NUM_KINDS;
  localparam int IDX_INSTR  = 2 * NUM_KINDS;
  localparam int IDX_CYCLE  = 2 * NUM_KINDS + 1;
  localparam int NUM_CNT    = 2 * NUM_KINDS + 2;
  localparam int RD_ADDR_W  = 4;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
    end else if (inc && (value != MAXV)) begin
      value <= value + 1'b1;
    end
  end

  // R9: an all-ones counter stays there
  a_r9_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (!clr && value == MAXV) |=> (value == MAXV));

  // R8: clear leaves zero behind
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (value == '0));

  // R9: without clear a counter never moves by more than one or backwards
  a_r9_step_one: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((value == $past(value)) || (value == $past(value) + 1'b1)));

endmodule

// File: rtl/txn_classifier.sv
module txn_classifier
  import txn_cnt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [1:0]           kind,
  input  logic                 freeze,
  output logic [NUM_KINDS-1:0] evt_inc,
  output logic [NUM_KINDS-1:0] frz_inc
);

  logic req_q;
  logic new_txn;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req;
  end

  assign new_txn = req & ~req_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic hit;
    assign hit        = (kind == k[1:0]);
    assign evt_inc[k] = new_txn & hit;
    assign frz_inc[k] = req & freeze & hit;
  end

  // R2: at most one kind counts an event in a cycle
  a_r2_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_inc));

  // R1: two consecutive cycles never both start a transaction
  a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
    (evt_inc != '0) |=> (evt_inc == '0));

  // R4: no freeze attribution without an outstanding request
  a_r4_freeze_gated: assert property (@(posedge clk) disable iff (rst)
    !req |-> (frz_inc == '0));

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import txn_cnt_pkg::*;
#(
  parameter int W = 32,
  parameter int N = NUM_CNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 snap,
  input  logic [N*W-1:0]       live,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [W-1:0]         rd_data,
  output logic                 rd_valid
);

  logic [W-1:0] shadow [N];

  for (genvar i = 0; i < N; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)       shadow[i] <= '0;
      else if (snap) shadow[i] <= live[i*W +: W];
    end

    // R7: snapshot captures the live value present in the snap cycle
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
      snap |=> (shadow[i] == $past(live[i*W +: W])));

    // R7: shadow holds without a snapshot
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !snap |=> $stable(shadow[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (int'(rd_addr) < N) rd_data <= shadow[rd_addr];
        else                   rd_data <= '0;
      end
    end
  end

  // R10: one-cycle read latency
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

// File: rtl/txn_stall_counters.sv
module txn_stall_counters
  import txn_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txn_req,
  input  logic [1:0]           txn_kind,
  input  logic                 cpu_freeze,
  input  logic                 instr_retire,
  input  logic                 snap,
  input  logic                 clr,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic                 rd_valid
);

  localparam int LIVE_W = NUM_CNT * CNT_W;

  logic [NUM_KINDS-1:0] evt_inc;
  logic [NUM_KINDS-1:0] frz_inc;
  logic [NUM_CNT-1:0]   inc_vec;
  logic [LIVE_W-1:0]    live;

  txn_classifier u_class (
    .clk     (clk),
    .rst     (rst),
    .req     (txn_req),
    .kind    (txn_kind),
    .freeze  (cpu_freeze),
    .evt_inc (evt_inc),
    .frz_inc (frz_inc)
  );

  assign inc_vec[IDX_EVT0 +: NUM_KINDS] = evt_inc;
  assign inc_vec[IDX_FRZ0 +: NUM_KINDS] = frz_inc;
  assign inc_vec[IDX_INSTR]             = instr_retire;
  assign inc_vec[IDX_CYCLE]             = 1'b1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .inc   (inc_vec[i]),
      .value (live[i*CNT_W +: CNT_W])
    );
  end

  shadow_bank #(.W(CNT_W), .N(NUM_CNT)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .snap     (snap),
    .live     (live),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R6: the cycle counter advances every cycle until it saturates
  a_r6_cycle_advance: assert property (@(posedge clk) disable iff (rst)
    (!clr && live[IDX_CYCLE*CNT_W +: CNT_W] != {CNT_W{1'b1}})
      |=> (live[IDX_CYCLE*CNT_W +: CNT_W] != '0));

  // R11: reset empties the read port
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_data == '0));

endmodule

// File: tb/sim_txn_stall_counters.sv
`timescale 1ns/1ps
module sim_txn_stall_counters;

  localparam int W    = 8;
  localparam int MAXV = 255;
  localparam int NC   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] kind = 2'd0;
  logic frz = 1'b0;
  logic ret = 1'b0;
  logic snap = 1'b0;
  logic clr = 1'b0;
  logic rd_en = 1'b0;
  logic [3:0] rd_addr = 4'd0;
  logic [W-1:0] rd_data;
  logic rd_valid;

  always #2.5 clk = ~clk;

  txn_stall_counters #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .txn_req(req), .txn_kind(kind), .cpu_freeze(frz),
    .instr_retire(ret), .snap(snap), .clr(clr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int fails  = 0;
  int live_m [NC];
  int shad_m [NC];
  bit req_q_m = 1'b0;
  int    exp_q [$];
  string tag_q [$];
  int    addr_q [$];

  function automatic int sat(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  // advance one clock and update the reference model from the requirements
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NC; i++) begin live_m[i] = 0; shad_m[i] = 0; end
      req_q_m = 1'b0;
    end else begin
      if (rd_en) begin
        exp_q.push_back((rd_addr < NC) ? shad_m[rd_addr] : 0);
        addr_q.push_back(int'(rd_addr));
      end
      if (snap) for (int i = 0; i < NC; i++) shad_m[i] = live_m[i];
      if (clr) begin
        for (int i = 0; i < NC; i++) live_m[i] = 0;
      end else begin
        if (req && !req_q_m) live_m[kind] = sat(live_m[kind]);
        if (req && frz)      live_m[4 + kind] = sat(live_m[4 + kind]);
        if (ret)             live_m[8] = sat(live_m[8]);
        live_m[9] = sat(live_m[9]);
      end
      req_q_m = req;
    end
    @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 12; a++) begin
      rd_en = 1'b1; rd_addr = a[3:0];
      tag_q.push_back(tag);
      tick();
    end
    rd_en = 1'b0;
    tick();
  endtask

  task automatic idle();
    req = 0; frz = 0; ret = 0; snap = 0; clr = 0;
  endtask

  // monitor: pops expected items and compares against the port
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected rd_valid: actual %0d expected none", rd_data);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int    a = addr_q.pop_front();
        if (int'(rd_data) != e) begin
          fails++;
          $display("FAIL %s (R10 addr %0d): actual %0d expected %0d", t, a, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    // R11: everything zero after reset
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R11 rd_valid after reset: actual %0b expected 0", rd_valid);
    end
    read_all("R11 reset state");

    // R1 R2 R3: long instruction miss, freeze on part of it
    for (int i = 0; i < 6; i++) begin
      req = 1; kind = 2'd0; frz = (i < 4); ret = (i % 3 == 0); tick();
    end
    // R4: freeze with no request outstanding
    idle(); frz = 1; tick();
    idle(); tick();
    for (int i = 0; i < 3; i++) begin req = 1; kind = 2'd1; frz = 1; tick(); end
    idle(); tick();
    req = 1; kind = 2'd2; frz = 1; tick();
    frz = 0; tick();
    idle(); tick();
    // R1: two one-cycle writes with a gap
    req = 1; kind = 2'd3; tick();
    idle(); tick();
    req = 1; kind = 2'd3; tick();
    idle();
    // R5 R6
    ret = 1; repeat (5) tick();
    idle(); snap = 1; tick(); idle();
    read_all("R2 R3 R4 R5 R6 after snapshot");

    // R7: new activity is hidden until the next snapshot
    for (int i = 0; i < 4; i++) begin req = 1; kind = 2'd1; frz = 1; ret = 1; tick(); end
    idle(); tick();
    read_all("R7 shadow unchanged without snap");

    // R8: snap and clear together
    snap = 1; clr = 1; tick(); idle();
    read_all("R8 snap with clear keeps pre-clear values");
    req = 1; kind = 2'd2; frz = 1; tick();
    idle(); tick();
    snap = 1; tick(); idle();
    read_all("R8 live counters restarted from zero");

    // R9: saturation, and R1 one event for a long request
    for (int i = 0; i < 300; i++) begin req = 1; kind = 2'd3; frz = 1; ret = 1; tick(); end
    idle(); snap = 1; tick(); idle();
    read_all("R9 saturation and R1 single event");

    repeat (3) tick();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule